// File: doc/BRIEF.md
# Row-and-Column Cut Approximate Multiplier

This block multiplies two unsigned operands and returns a product that is exact only when no cells are removed. It is built as an array multiplier. AND gates form the partial-product bits, rows of full-adder and half-adder cells fold those bits together in carry-save form, and a ripple adder merges the last sum and carry vectors. Two elaboration parameters remove part of the array. `ROW_CUT` removes every partial-product row driven by an `op_b` bit below that index. `COL_CUT` removes every partial-product bit whose weight lies below that column. The cells that would have summed the removed bits are left out, which saves area and delay. In exchange, the result carries an error whose size is set by the two cuts alone.

The block has no clock, no state and no handshake. It is purely combinational, and `prod` follows the operands. It is meant for error-tolerant datapaths, such as filter or neural-network arithmetic, where the cut parameters are chosen to trade accuracy against cell count. Out-of-range parameter values stop elaboration: `ROW_CUT` must be between 0 and `N`, and `COL_CUT` between 0 and `2*N`.

Top module: `cutarray_mul`

## Requirements
- R1: `prod` equals the sum of 2^(i+j) over every pair (i, j) with `op_a[i]`=1 and `op_b[j]`=1 where j >= `ROW_CUT` and i+j >= `COL_CUT`. Here i indexes `op_a`, j indexes `op_b`, and bit 0 is the least significant.
- R2: With `ROW_CUT`=0 and `COL_CUT`=0, `prod` equals the exact unsigned product for every operand pair.
- R3: With `N`=8, `ROW_CUT`=4 and `COL_CUT`=4, operands 43 and 84 give 3440 (the exact product is 3612).
- R4: `prod` is never greater than the exact product `op_a`*`op_b`.
- R5: Every bit of `prod` below position `COL_CUT` is zero.
- R6: `prod` is zero whenever `op_a` is zero or `op_b` has no set bit at or above index `ROW_CUT`. With `ROW_CUT`=`N`, this means `prod` is always zero.
- R7: With `N`=8, `ROW_CUT`=4 and `COL_CUT`=4, the absolute errors |exact - `prod`| summed over all 65536 operand pairs total 62668800, which is a mean of 956.25.
- R8: The block holds no state. A new operand pair yields its R1 result with no clock edge in between, whatever pair came before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | N | Multiplicand, unsigned |
| op_b | input | N | Multiplier, unsigned; its bit j selects partial-product row j |
| prod | output | 2*N | Approximate unsigned product |

## Verification
The bench builds four copies at `N`=8, all driven with the same operands, and sweeps every one of the 65536 operand pairs.
- Cuts (4,4): reaches the 43×84 spot value and the exact total of the absolute error.
- Cuts (0,0): must agree with true multiplication everywhere.
- Cuts (3,9): a skewed setting in which the column cut passes above the row cut, so whole columns and partial rows both vanish.
- Cuts (8,0): removes every row and so exercises the all-zero edge of the row cut.

// File: rtl/cutarray_pkg.sv
package cutarray_pkg;

  // True when partial-product bit op_a[a_idx] & op_b[b_idx] survives both cuts.
  function automatic bit pp_kept(int a_idx, int b_idx, int row_cut, int col_cut);
    return (b_idx >= row_cut) && ((a_idx + b_idx) >= col_cut);
  endfunction

  // True when row b_idx (N bits wide) keeps at least one bit.
  function automatic bit row_live(int b_idx, int n, int row_cut, int col_cut);
    return (b_idx >= row_cut) && ((b_idx + n - 1) >= col_cut);
  endfunction

endpackage

// File: rtl/cutarray_fa.sv
module cutarray_fa (
  input  logic x,
  input  logic y,
  input  logic cin,
  output logic s,
  output logic cout
);
  logic xy;
  assign xy   = x ^ y;
  assign s    = xy ^ cin;
  assign cout = (x & y) | (cin & xy);
endmodule

// File: rtl/cutarray_ha.sv
module cutarray_ha (
  input  logic x,
  input  logic y,
  output logic s,
  output logic cout
);
  assign s    = x ^ y;
  assign cout = x & y;
endmodule

// File: rtl/cutarray_ppgen.sv
module cutarray_ppgen #(
  parameter int N       = 8,
  parameter int ROW_CUT = 4,
  parameter int COL_CUT = 4
) (
  input  logic [N-1:0]          op_a,
  input  logic [N-1:0]          op_b,
  output logic [N-1:0][2*N-1:0] rows
);
  localparam int W = 2 * N;

  // Bits removed by the cuts leave operand bits unread; gather them here.
  logic unused_ops;
  assign unused_ops = ^{op_a, op_b};

  for (genvar j = 0; j < N; j++) begin : g_row
    for (genvar k = 0; k < W; k++) begin : g_bit
      localparam int AI = k - j;
      if (AI >= 0 && AI < N && cutarray_pkg::pp_kept(AI, j, ROW_CUT, COL_CUT)) begin : g_keep
        assign rows[j][k] = op_a[AI] & op_b[j];
      end else begin : g_drop
        assign rows[j][k] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/cutarray_csa_stage.sv
module cutarray_csa_stage #(
  parameter int N       = 8,
  parameter int ROW     = 1,
  parameter int ROW_CUT = 4,
  parameter int COL_CUT = 4
) (
  input  logic [2*N-1:0] sum_in,
  input  logic [2*N-1:0] carry_in,
  input  logic [2*N-1:0] addend,
  output logic [2*N-1:0] sum_out,
  output logic [2*N-1:0] carry_out
);
  localparam int W = 2 * N;

  logic unused_addend;

  if (!cutarray_pkg::row_live(ROW, N, ROW_CUT, COL_CUT)) begin : g_bypass
    // Whole row removed: no cells, vectors pass straight on.
    assign sum_out       = sum_in;
    assign carry_out     = carry_in;
    assign unused_addend = ^addend;
  end else begin : g_cells
    logic [W-1:0] cgen;
    for (genvar k = 0; k < W; k++) begin : g_col
      localparam int AI = k - ROW;
      if (AI >= 0 && AI < N && cutarray_pkg::pp_kept(AI, ROW, ROW_CUT, COL_CUT)) begin : g_fa
        cutarray_fa u_fa (
          .x(sum_in[k]), .y(carry_in[k]), .cin(addend[k]),
          .s(sum_out[k]), .cout(cgen[k])
        );
      end else begin : g_ha
        cutarray_ha u_ha (
          .x(sum_in[k]), .y(carry_in[k]),
          .s(sum_out[k]), .cout(cgen[k])
        );
      end
    end
    // Carries move one column up; the top one cannot be set since the result fits W bits.
    assign carry_out     = {cgen[W-2:0], 1'b0};
    assign unused_addend = ^{addend, cgen[W-1]};
  end
endmodule

// File: rtl/cutarray_cpa.sv
module cutarray_cpa #(
  parameter int W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] total
);
  logic [W:0] chain;
  logic       unused_cout;

  assign chain[0] = 1'b0;
  for (genvar k = 0; k < W; k++) begin : g_bit
    cutarray_fa u_fa (
      .x(x[k]), .y(y[k]), .cin(chain[k]),
      .s(total[k]), .cout(chain[k+1])
    );
  end
  assign unused_cout = chain[W];
endmodule

// File: rtl/cutarray_mul.sv
module cutarray_mul #(
  parameter int N       = 8,
  parameter int ROW_CUT = 4,
  parameter int COL_CUT = 4
) (
  input  logic [N-1:0]   op_a,
  input  logic [N-1:0]   op_b,
  output logic [2*N-1:0] prod
);
  localparam int W = 2 * N;

  if (N < 1) begin : g_bad_n
    $error("cutarray_mul: N must be at least 1");
  end
  if (ROW_CUT < 0 || ROW_CUT > N) begin : g_bad_row
    $error("cutarray_mul: ROW_CUT outside 0..N");
  end
  if (COL_CUT < 0 || COL_CUT > W) begin : g_bad_col
    $error("cutarray_mul: COL_CUT outside 0..2N");
  end

  logic [N-1:0][W-1:0] pp_rows;
  logic [N-1:0][W-1:0] sum_q;
  logic [N-1:0][W-1:0] carry_q;

  cutarray_ppgen #(.N(N), .ROW_CUT(ROW_CUT), .COL_CUT(COL_CUT)) u_ppgen (
    .op_a(op_a), .op_b(op_b), .rows(pp_rows)
  );

  assign sum_q[0]   = pp_rows[0];
  assign carry_q[0] = '0;

  for (genvar j = 1; j < N; j++) begin : g_stage
    cutarray_csa_stage #(.N(N), .ROW(j), .ROW_CUT(ROW_CUT), .COL_CUT(COL_CUT)) u_stage (
      .sum_in   (sum_q[j-1]),
      .carry_in (carry_q[j-1]),
      .addend   (pp_rows[j]),
      .sum_out  (sum_q[j]),
      .carry_out(carry_q[j])
    );
  end

  cutarray_cpa #(.W(W)) u_cpa (
    .x(sum_q[N-1]), .y(carry_q[N-1]), .total(prod)
  );
endmodule

// File: rtl/cutarray_mul_chk.sv
module cutarray_mul_chk #(
  parameter int N       = 8,
  parameter int ROW_CUT = 4,
  parameter int COL_CUT = 4
) (
  input logic [N-1:0]   op_a,
  input logic [N-1:0]   op_b,
  input logic [2*N-1:0] prod
);
  localparam int W = 2 * N;

  logic [W-1:0] exact;
  assign exact = W'(op_a) * W'(op_b);

  always_comb begin
    if (!$isunknown({op_a, op_b, prod})) begin
      // R4
      no_excess_chk: assert (prod <= exact)
        else $error("prod %0d above exact %0d", prod, exact);
      // R6
      dead_rows_zero_chk: assert (!((op_a == '0) || ((op_b >> ROW_CUT) == '0)) || (prod == '0))
        else $error("prod %0d not zero for removed rows", prod);
    end
  end

  if (COL_CUT > 0) begin : g_low
    localparam int LB = (COL_CUT > W) ? W : COL_CUT;
    always_comb begin
      if (!$isunknown(prod)) begin
        // R5
        low_cols_zero_chk: assert (prod[LB-1:0] == '0)
          else $error("low columns of prod %0h not zero", prod);
      end
    end
  end

  if (ROW_CUT == 0 && COL_CUT == 0) begin : g_exact
    always_comb begin
      if (!$isunknown({op_a, op_b, prod})) begin
        // R2
        exact_when_uncut_chk: assert (prod == exact)
          else $error("uncut prod %0d differs from %0d", prod, exact);
      end
    end
  end
endmodule

bind cutarray_mul cutarray_mul_chk #(.N(N), .ROW_CUT(ROW_CUT), .COL_CUT(COL_CUT)) u_chk (
  .op_a(op_a), .op_b(op_b), .prod(prod)
);

// File: tb/cutarray_mul_bench.sv
module cutarray_mul_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [7:0]  a_in = '0;
  logic [7:0]  b_in = '0;
  logic [15:0] p_main, p_exact, p_skew, p_full;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  cutarray_mul #(.N(8), .ROW_CUT(4), .COL_CUT(4)) u_cutarray_mul (.op_a(a_in), .op_b(b_in), .prod(p_main));
  cutarray_mul #(.N(8), .ROW_CUT(0), .COL_CUT(0)) u_exact (.op_a(a_in), .op_b(b_in), .prod(p_exact));
  cutarray_mul #(.N(8), .ROW_CUT(3), .COL_CUT(9)) u_skew  (.op_a(a_in), .op_b(b_in), .prod(p_skew));
  cutarray_mul #(.N(8), .ROW_CUT(8), .COL_CUT(0)) u_full  (.op_a(a_in), .op_b(b_in), .prod(p_full));

  function automatic int ref_prod(int a, int b, int rc, int cc);
    int acc = 0;
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        if (((a >> i) & 1) == 1 && ((b >> j) & 1) == 1 && j >= rc && (i + j) >= cc)
          acc += (1 << (i + j));
    return acc;
  endfunction

  task automatic check(bit ok, string req, longint actual, longint expected);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s a=%0d b=%0d actual=%0d expected=%0d", req, a_in, b_in, actual, expected);
    end
  endtask

  initial begin
    longint err_sum = 0;
    #2;
    // R6: all-zero operands give zero
    check(p_main == 16'd0, "R6", p_main, 0);
    check(p_exact == 16'd0, "R2", p_exact, 0);
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        int ex, rm, rs;
        @(negedge clk);
        a_in = 8'(a);
        b_in = 8'(b);
        #2;
        ex = a * b;
        rm = ref_prod(a, b, 4, 4);
        rs = ref_prod(a, b, 3, 9);
        // R1 and R8: result present with no clock edge since the operands changed
        check(int'(p_main) == rm, "R1", p_main, rm);
        check(int'(p_skew) == rs, "R1", p_skew, rs);
        check(int'(p_exact) == ex, "R2", p_exact, ex);
        check(int'(p_main) <= ex && int'(p_skew) <= ex, "R4", p_main, ex);
        check((p_main[3:0] == 4'd0) && (p_skew[8:0] == 9'd0), "R5", p_skew, 0);
        check(p_full == 16'd0, "R6", p_full, 0);
        if (a == 0 || (b >> 4) == 0)
          check(p_main == 16'd0, "R6", p_main, 0);
        err_sum += longint'(ex - int'(p_main));
      end
    end
    // R7: total absolute error at cuts (4,4)
    check(err_sum == 64'd62668800, "R7", err_sum, 62668800);
    // R3: spot value, then R8: same pair reached from a different previous pair
    @(negedge clk);
    a_in = 8'd43; b_in = 8'd84;
    #2;
    check(p_main == 16'd3440, "R3", p_main, 3440);
    a_in = 8'd255; b_in = 8'd255;
    #1;
    check(int'(p_main) == ref_prod(255, 255, 4, 4), "R8", p_main, ref_prod(255, 255, 4, 4));
    a_in = 8'd43; b_in = 8'd84;
    #1;
    check(p_main == 16'd3440, "R8", p_main, 3440);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule